// File: doc/BRIEF.md
# Patch Image Checksum Validator

This block inspects a patch image as it streams past, one 32-bit dword on each cycle where the valid input is high. It does not store the image. It picks the geometry and identity fields out of the fixed-size header as they go by. It then sizes the image and any trailing extended signature table from those fields. While the image streams, it keeps running modular sums. After the last dword it reports pass, or it reports a single error code that names the first rule the image broke.

The header is `HDR_BYTES` bytes long (default 48, so 12 dwords). The data section follows the header. An optional extended table follows the data. The table starts with a 20-byte table header: a count dword, a checksum dword and three reserved dwords. After that come `count` entries of 12 bytes each. Each entry holds a signature, a platform mask and a checksum, in that order. The image length is taken from the header. Some errors make the length untrustworthy: a size error, a format error or a truncated table. In those cases the result is issued right after the last header dword, and the next dword starts a new image.

Top module: `pcv_image_checker`

## Requirements
- R1: Header dword positions: 0 header version, 3 signature, 4 checksum, 5 loader version, 6 platform mask, 7 data size in bytes, 8 total size in bytes. Dwords 1, 2, 9, 10 and 11 enter only the sum. Code 1 (size) is reported in any of these cases: the effective data size plus the header size exceeds the effective total size; either effective size is not a multiple of 4; or the total reaches 2^(CNT_W+2) bytes.
- R2: Code 2 (format) is reported when the loader version is not 1, or when the header version differs from `exp_type_i`.
- R3: A data size field of zero selects a data size of `DEF_DATA_BYTES` (2000) and a total of `DEF_DATA_BYTES + HDR_BYTES` (2048). The total size field is then ignored.
- R4: The table size is the effective total minus the header minus the data. Code 3 (truncated table) is reported when the table size is nonzero and either is below 20 or leaves a remainder that is not a multiple of 12.
- R5: Code 4 (table size mismatch) is reported when the table size differs from count × 12 + 20. The count is the first table dword.
- R6: Code 5 (table checksum) is reported when a table is present and the 32-bit wrapping sum of all its dwords is not zero.
- R7: Code 6 (data checksum) is reported when the 32-bit wrapping sum of all header and data dwords is not zero.
- R8: Code 7 (entry checksum) is reported when, for some entry, (header signature + platform mask + checksum) − (entry signature + platform mask + checksum) is not zero modulo 2^32.
- R9: When several rules fail, the lowest code is reported. Codes 1 to 3 end the image at its 12th dword. Otherwise the image ends at dword number total/4.
- R10: `done_o` pulses for one cycle, in the cycle after the final dword is accepted. `err_o` holds the code (0 = pass), and `pass_o` is high exactly when the code is 0. Both hold until the next result. Reset clears all three.
- R11: A cycle with `in_valid_i` low does not change the progress or the sums, whatever `in_dword_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_type_i | input | 32 | Header version the image must carry |
| in_valid_i | input | 1 | Dword on `in_dword_i` is accepted this cycle |
| in_dword_i | input | 32 | Image dword |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Last image passed every check |
| err_o | output | 3 | Code of the first failed rule, 0 when passed |

## Verification
The stimulus covers several kinds of image:
- Clean images with no table, with the default size, and with one to three entries. These show that a valid image passes in each geometry.
- Images with one rule broken. Each of these confirms that the matching code appears on its own.
- Images with two rules broken. These show the priority order, and they show the early end of the image after the header.

Random images with random sizes, table shapes and corruptions are streamed with idle gaps that carry garbage data. They are compared with a software model of the rules, which separates dwords that are ignored from dwords that are counted.

// File: rtl/pcv_pkg.sv
`timescale 1ns/1ps
package pcv_pkg;

    localparam int PCV_TBL_HDR_BYTES = 20;
    localparam int PCV_ENTRY_BYTES   = 12;

    localparam int PCV_W_HDRVER = 0;
    localparam int PCV_W_SIG    = 3;
    localparam int PCV_W_CKSUM  = 4;
    localparam int PCV_W_LDRVER = 5;
    localparam int PCV_W_PFMASK = 6;
    localparam int PCV_W_DSIZE  = 7;
    localparam int PCV_W_TSIZE  = 8;

    typedef enum logic [2:0] {
        PCV_OK        = 3'd0,
        PCV_E_SIZE    = 3'd1,
        PCV_E_FORMAT  = 3'd2,
        PCV_E_TRUNC   = 3'd3,
        PCV_E_TBLSIZE = 3'd4,
        PCV_E_TBLSUM  = 3'd5,
        PCV_E_DATASUM = 3'd6,
        PCV_E_ENTRY   = 3'd7
    } pcv_err_e;

    typedef struct packed {
        logic [31:0] hdr_ver;
        logic [31:0] sig;
        logic [31:0] cksum;
        logic [31:0] ldr_ver;
        logic [31:0] pf_mask;
        logic [31:0] data_bytes;
        logic [31:0] total_bytes;
    } pcv_hdr_t;

    // flags bit k set means rule with code k+1 failed; lowest code wins
    function automatic pcv_err_e pcv_first_err(input logic [6:0] flags);
        pcv_err_e r;
        r = PCV_OK;
        for (int k = 6; k >= 0; k--) begin
            if (flags[k]) r = pcv_err_e'(3'(k + 1));
        end
        return r;
    endfunction

endpackage

// File: rtl/pcv_field_capture.sv
`timescale 1ns/1ps
module pcv_field_capture
    import pcv_pkg::*;
#(
    parameter int HDR_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic [CNT_W-1:0] idx,
    input  logic [31:0]      dword,
    output pcv_hdr_t         hdr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
        end else if (beat) begin
            case (int'(idx))
                PCV_W_HDRVER: hdr.hdr_ver     <= dword;
                PCV_W_SIG:    hdr.sig         <= dword;
                PCV_W_CKSUM:  hdr.cksum       <= dword;
                PCV_W_LDRVER: hdr.ldr_ver     <= dword;
                PCV_W_PFMASK: hdr.pf_mask     <= dword;
                PCV_W_DSIZE:  hdr.data_bytes  <= dword;
                PCV_W_TSIZE:  hdr.total_bytes <= dword;
                default: ;
            endcase
        end
    end

    // geometry fields must not move once the body of an image streams
    assert_fields_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        (beat && int'(idx) >= HDR_W) |=> $stable(hdr));

endmodule

// File: rtl/pcv_geometry.sv
`timescale 1ns/1ps
module pcv_geometry
    import pcv_pkg::*;
#(
    parameter int HDR_BYTES      = 48,
    parameter int DEF_DATA_BYTES = 2000,
    parameter int CNT_W          = 16
) (
    input  pcv_hdr_t         hdr,
    input  logic [31:0]      exp_type,
    output logic [CNT_W-1:0] data_words,
    output logic [CNT_W-1:0] total_words,
    output logic [31:0]      ext_bytes,
    output logic             size_err,
    output logic             fmt_err,
    output logic             trunc_err
);

    logic [31:0] data_eff;
    logic [31:0] total_eff;
    logic [32:0] need;
    logic [31:0] ext_rem;

    always_comb begin
        if (hdr.data_bytes == '0) begin
            data_eff  = 32'(DEF_DATA_BYTES);
            total_eff = 32'(DEF_DATA_BYTES + HDR_BYTES);
        end else begin
            data_eff  = hdr.data_bytes;
            total_eff = hdr.total_bytes;
        end
        need      = {1'b0, data_eff} + 33'(HDR_BYTES);
        size_err  = (need > {1'b0, total_eff}) || (|data_eff[1:0]) || (|total_eff[1:0])
                  || (|total_eff[31:CNT_W+2]) || (|data_eff[31:CNT_W+2]);
        fmt_err   = (hdr.ldr_ver != 32'd1) || (hdr.hdr_ver != exp_type);
        ext_bytes = total_eff - 32'(HDR_BYTES) - data_eff;
        ext_rem   = (ext_bytes - 32'(PCV_TBL_HDR_BYTES)) % 32'(PCV_ENTRY_BYTES);
        trunc_err = !size_err && (ext_bytes != '0)
                  && ((ext_bytes < 32'(PCV_TBL_HDR_BYTES)) || (ext_rem != '0));
        data_words  = data_eff[CNT_W+1:2];
        total_words = total_eff[CNT_W+1:2];
    end

endmodule

// File: rtl/pcv_entry_check.sv
`timescale 1ns/1ps
module pcv_entry_check (
    input  logic        clk,
    input  logic        rst,
    input  logic        beat,
    input  logic        in_ent,
    input  logic [31:0] dword,
    input  logic [31:0] prim_sum,
    output logic        bad_now
);

    logic [1:0]  phase;
    logic [31:0] part;

    assign bad_now = beat && in_ent && (phase == 2'd2)
                   && ((prim_sum - (part + dword)) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            part  <= '0;
        end else if (beat) begin
            if (!in_ent || phase == 2'd2) begin
                phase <= '0;
                part  <= '0;
            end else begin
                phase <= phase + 2'd1;
                part  <= part + dword;
            end
        end
    end

endmodule

// File: rtl/pcv_image_checker.sv
`timescale 1ns/1ps
module pcv_image_checker
    import pcv_pkg::*;
#(
    parameter int HDR_BYTES      = 48,
    parameter int DEF_DATA_BYTES = 2000,
    parameter int CNT_W          = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] exp_type_i,
    input  logic        in_valid_i,
    input  logic [31:0] in_dword_i,
    output logic        done_o,
    output logic        pass_o,
    output logic [2:0]  err_o
);

    localparam int HDR_W = HDR_BYTES / 4;

    pcv_hdr_t         hdr;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] data_words;
    logic [CNT_W-1:0] total_words;
    logic [31:0]      ext_bytes;
    logic             size_err, fmt_err, trunc_err;
    logic [31:0]      main_sum, tbl_sum, main_nxt, tbl_nxt;
    logic             f_tblsize, f_entry;
    logic             ent_bad;

    pcv_field_capture #(.HDR_W(HDR_W), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .beat(in_valid_i), .idx(idx), .dword(in_dword_i), .hdr(hdr)
    );

    pcv_geometry #(.HDR_BYTES(HDR_BYTES), .DEF_DATA_BYTES(DEF_DATA_BYTES), .CNT_W(CNT_W)) u_geo (
        .hdr(hdr), .exp_type(exp_type_i), .data_words(data_words), .total_words(total_words),
        .ext_bytes(ext_bytes), .size_err(size_err), .fmt_err(fmt_err), .trunc_err(trunc_err)
    );

    logic [CNT_W:0] idx_x, main_end, tbl_t;
    logic           in_main, in_tbl, in_ent, hdr_last, at_end, last, cnt_bad;
    logic [6:0]     flags;
    pcv_err_e       code;

    always_comb begin
        idx_x    = {1'b0, idx};
        main_end = (CNT_W+1)'(HDR_W) + {1'b0, data_words};
        in_main  = idx_x < main_end;
        in_tbl   = !in_main;
        tbl_t    = idx_x - main_end;
        in_ent   = in_tbl && (tbl_t >= (CNT_W+1)'(5));
        hdr_last = (idx == CNT_W'(HDR_W - 1));
        at_end   = (idx_x >= (CNT_W+1)'(HDR_W)) && (idx_x == {1'b0, total_words} - 1'b1);
        last     = in_valid_i && ((hdr_last && (size_err || fmt_err || trunc_err)) || at_end);
        main_nxt = main_sum + (in_main ? in_dword_i : 32'd0);
        tbl_nxt  = tbl_sum + (in_tbl ? in_dword_i : 32'd0);
        cnt_bad  = in_valid_i && in_tbl && (tbl_t == '0)
                 && (({4'b0, in_dword_i} * 36'(PCV_ENTRY_BYTES) + 36'(PCV_TBL_HDR_BYTES))
                     != {4'b0, ext_bytes});
        if (hdr_last)
            flags = {4'b0000, trunc_err, fmt_err, size_err};
        else
            flags = {f_entry || ent_bad, main_nxt != '0,
                     (ext_bytes != '0) && (tbl_nxt != '0), f_tblsize || cnt_bad, 3'b000};
        code = pcv_first_err(flags);
    end

    pcv_entry_check u_ent (
        .clk(clk), .rst(rst), .beat(in_valid_i), .in_ent(in_ent), .dword(in_dword_i),
        .prim_sum(hdr.sig + hdr.pf_mask + hdr.cksum), .bad_now(ent_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            main_sum  <= '0;
            tbl_sum   <= '0;
            f_tblsize <= 1'b0;
            f_entry   <= 1'b0;
            done_o    <= 1'b0;
            pass_o    <= 1'b0;
            err_o     <= '0;
        end else begin
            done_o <= last;
            if (last) begin
                err_o  <= code;
                pass_o <= (code == PCV_OK);
            end
            if (in_valid_i) begin
                if (last) begin
                    idx       <= '0;
                    main_sum  <= '0;
                    tbl_sum   <= '0;
                    f_tblsize <= 1'b0;
                    f_entry   <= 1'b0;
                end else begin
                    idx       <= idx + 1'b1;
                    main_sum  <= main_nxt;
                    tbl_sum   <= tbl_nxt;
                    f_tblsize <= f_tblsize || cnt_bad;
                    f_entry   <= f_entry || ent_bad;
                end
            end
        end
    end

    assert_done_after_beat_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(in_valid_i));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_idx_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && int'(idx) >= HDR_W) |-> (idx < total_words));

    assert_entry_needs_table_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o == PCV_E_ENTRY) |-> (ext_bytes != '0));

endmodule

// File: tb/pcv_image_checker_tb.sv
`timescale 1ns/1ps
module pcv_image_checker_tb;

    localparam logic [31:0] EXP = 32'h1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_dword_i = '0;
    logic        done_o, pass_o;
    logic [2:0]  err_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] img [0:1023];

    always #2.5 clk = ~clk;

    pcv_image_checker u_dut (
        .clk(clk), .rst(rst), .exp_type_i(EXP), .in_valid_i(in_valid_i),
        .in_dword_i(in_dword_i), .done_o(done_o), .pass_o(pass_o), .err_o(err_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, act cycles=%0d exp<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // software model of the rules; returns code, sets dwords to send
    function automatic int ref_code(output int len);
        longint de, te, ext, n, base, e;
        logic [31:0] s, prim;
        de = (img[7] == 0) ? 2000 : longint'(img[7]);
        te = (img[7] == 0) ? 2048 : longint'(img[8]);
        len = 12;
        if ((de % 4) != 0 || (te % 4) != 0 || de + 48 > te || te >= 262144) return 1;
        if (img[5] != 32'd1 || img[0] != EXP) return 2;
        ext = te - 48 - de;
        if (ext != 0 && (ext < 20 || ((ext - 20) % 12) != 0)) return 3;
        len = int'(te / 4);
        base = 12 + de / 4;
        if (ext != 0 && ext != longint'(img[base]) * 12 + 20) return 4;
        if (ext != 0) begin
            s = 0;
            for (longint i = base; i < te / 4; i++) s += img[i];
            if (s != 0) return 5;
        end
        s = 0;
        for (longint i = 0; i < base; i++) s += img[i];
        if (s != 0) return 6;
        if (ext != 0) begin
            n = (ext - 20) / 12;
            prim = img[3] + img[4] + img[6];
            for (longint i = 0; i < n; i++) begin
                e = base + 5 + 3 * i;
                if (prim - (img[e] + img[e+1] + img[e+2]) != 0) return 7;
            end
        end
        return 0;
    endfunction

    // corrupt: bit0 data dword, bit1 table reserved dword, bit2 last entry checksum
    task automatic build(input int ds, input int ts, input int n_ent, input int cnt_adj,
                         input int corrupt);
        int de, te, nw, mw, base;
        logic [31:0] s, prim;
        de = (ds == 0) ? 2000 : ds;
        te = (ds == 0) ? 2048 : ts;
        nw = te / 4; if (nw > 1024) nw = 1024;
        for (int i = 0; i < nw; i++) img[i] = $urandom;
        img[0] = EXP; img[5] = 1; img[7] = ds; img[8] = ts; img[4] = 0;
        mw = 12 + de / 4; if (mw > nw) mw = nw;
        s = 0;
        for (int i = 0; i < mw; i++) s += img[i];
        img[4] = -s;
        if (corrupt[0]) img[12] ^= 32'h10;
        if (te - 48 - de >= 20 && nw > mw) begin
            base = mw;
            img[base] = n_ent + cnt_adj; img[base+1] = 0;
            prim = img[3] + img[4] + img[6];
            for (int i = 0; i < n_ent; i++) begin
                int e;
                e = base + 5 + 3 * i;
                if (e + 2 < nw) begin
                    img[e+2] = prim - img[e] - img[e+1];
                    if (corrupt[2] && i == n_ent - 1) img[e+2] += 1;
                end
            end
            s = 0;
            for (int i = base; i < nw; i++) s += img[i];
            img[base+1] = -s;
            if (corrupt[1]) img[base+2] ^= 32'h1;
        end
    endtask

    task automatic send_and_check(input string req, input int exp_code, input bit gaps);
        int len, rc;
        bit early;
        rc = ref_code(len);
        check(req, rc == exp_code, "model code", rc, exp_code);
        early = 0;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 3) == 0) begin
                @(negedge clk);
                if (done_o) early = 1;
                in_valid_i = 1'b0; in_dword_i = $urandom;
            end
            @(negedge clk);
            if (done_o) early = 1;
            in_valid_i = 1'b1; in_dword_i = img[i];
        end
        @(negedge clk);
        in_valid_i = 1'b0; in_dword_i = $urandom;
        check("R10", !early, "done before final dword", int'(early), 0);
        check(req, done_o == 1'b1, "done strobe", int'(done_o), 1);
        check(req, err_o == 3'(exp_code), "error code", int'(err_o), exp_code);
        check("R10", pass_o == (exp_code == 0), "pass flag", int'(pass_o), int'(exp_code == 0));
        @(negedge clk);
        check("R10", done_o == 1'b0, "done width", int'(done_o), 0);
        check("R10", err_o == 3'(exp_code), "code held", int'(err_o), exp_code);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", {done_o, pass_o, err_o} == 5'b0, "reset outputs",
              int'({done_o, pass_o, err_o}), 0);

        build(64, 112, 0, 0, 0);           send_and_check("R7", 0, 0);
        build(0, 7, 0, 0, 0);              send_and_check("R3", 0, 0);
        build(64, 48+64+20+24, 2, 0, 0);   send_and_check("R8", 0, 1);
        build(40, 48+40+20, 0, 0, 0);      send_and_check("R6", 0, 0);
        build(200, 100, 0, 0, 0);          send_and_check("R1", 1, 0);
        build(62, 110, 0, 0, 0);           send_and_check("R1", 1, 0);
        build(64, 262144, 0, 0, 0);        send_and_check("R1", 1, 0);
        build(64, 112, 0, 0, 0); img[5] = 2;        send_and_check("R2", 2, 0);
        build(64, 112, 0, 0, 0); img[0] = EXP + 1;  send_and_check("R2", 2, 0);
        build(64, 48+64+16, 0, 0, 0);      send_and_check("R4", 3, 0);
        build(64, 48+64+28, 0, 0, 0);      send_and_check("R4", 3, 0);
        build(64, 48+64+20+24, 2, 1, 0);   send_and_check("R5", 4, 0);
        build(64, 48+64+20+24, 2, 0, 2);   send_and_check("R6", 5, 0);
        build(64, 112, 0, 0, 1);           send_and_check("R7", 6, 0);
        build(64, 48+64+20+36, 3, 0, 4);   send_and_check("R8", 7, 0);
        build(200, 100, 0, 0, 0); img[5] = 3;       send_and_check("R9", 1, 0);
        build(64, 48+64+20+24, 2, 0, 3);   send_and_check("R9", 5, 0);
        build(64, 48+64+20+24, 2, 0, 5);   send_and_check("R9", 6, 0);
        build(32, 48+32+20+12, 1, 0, 0);   send_and_check("R11", 0, 1);

        for (int t = 0; t < 40; t++) begin
            int ds, n, ts, adj, cor, rc, len;
            ds  = 4 * (1 + int'($urandom % 20));
            n   = int'($urandom % 4);
            ts  = 48 + ds + ((($urandom % 2) == 1) ? 20 + 12 * n : 0);
            adj = (($urandom % 6) == 0) ? 1 : 0;
            cor = (($urandom % 2) == 1) ? int'($urandom % 8) : 0;
            if (($urandom % 8) == 0) ts += 4;
            build(ds, ts, n, adj, cor);
            if (($urandom % 10) == 0) img[5] = 0;
            rc = ref_code(len);
            send_and_check("R11", rc, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule